// File: doc/BRIEF.md
# Address-Encoded Burst Length Window

This block sits in the data phase of a card-side block-transfer command. It lies between the command decoder and a byte-wide DMA stream. When a burst starts, the block takes the 17-bit function address and the byte or block count from the decoded command.

The address decides how many bytes reach or leave the DMA stream. The payload length is the distance from the address up to the window end at 0x1F800. The count field only sets how many byte slots the bus runs in total. On a read, which moves data from the card to the host, the payload bytes are taken from the DMA stream and any further bus slots carry 0x00. On a write, which moves data from the host to the card, the payload bytes are forwarded to the DMA stream and any further bus bytes are dropped.

When the count is too short to cover the address-derived length, the block flags an underrun, reports the missing byte count, and ends the burst when the count runs out. Each burst ends with a one-cycle done pulse that carries the number of payload bytes moved.

Top module: `blen_window`

## Requirements
- R1: The requested length is 0x1F800 minus `cmd_addr`; an address at or above 0x1F800 gives a requested length of 0, so no byte touches the DMA stream.
- R2: With `cmd_block`=0 the transfer length is `cmd_count`, and a count of 0 means 512 bytes; the burst runs exactly that many bus byte transfers.
- R3: With `cmd_block`=1 the transfer length is `cmd_count` × `blk_size`; a product of 0 ends the burst without any bus transfer, and the done pulse comes one cycle after the start.
- R4: On a read burst (`cmd_read`=1), the first min(requested, transfer) bus bytes are the DMA input bytes in order, with `bus_rdata` equal to `dma_rd_data`. Every later bus byte is 0x00 and pulls nothing from the DMA input.
- R5: On a write burst (`cmd_read`=0), the first min(requested, transfer) bus bytes go to `dma_wr_data` unchanged. Later bus bytes are accepted but `dma_wr_valid` stays low for them.
- R6: When the transfer length is shorter than the requested length, `underrun` is 1 and `shortfall` equals requested minus transfer; otherwise both are 0. Both are set one cycle after the start and held until the next start is accepted.
- R7: A bus byte transfers only on a cycle where both `bus_stb` and `bus_ack` are 1. In the payload part, `bus_ack` follows `dma_rd_valid` on reads and `dma_wr_ready` on writes. In the tail part, `bus_ack` is 1.
- R8: One cycle after the last bus byte transfer, `done` pulses for exactly one cycle and `busy` falls. `done_bytes` then holds the payload byte count, min(requested, transfer).
- R9: A `start` seen while `busy` is 1 is ignored: it does not change the burst in progress.
- R10: After reset the block is idle. `busy`, `done`, `bus_ack`, `dma_wr_valid` and `dma_rd_ready` are 0, and `bus_ack` stays 0 for as long as the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst with the command fields below (taken only when idle) |
| cmd_addr | input | 17 | Function address from the command |
| cmd_count | input | 9 | Byte or block count from the command |
| cmd_block | input | 1 | 1 = block mode, 0 = byte mode |
| cmd_read | input | 1 | 1 = card-to-host, 0 = host-to-card |
| blk_size | input | 12 | Configured block size in bytes |
| bus_stb | input | 1 | Bus side offers or wants one byte this cycle |
| bus_ack | output | 1 | Block can take or give that byte this cycle |
| bus_wdata | input | 8 | Byte from the bus on writes |
| bus_rdata | output | 8 | Byte to the bus on reads |
| dma_rd_valid | input | 1 | DMA input byte available |
| dma_rd_ready | output | 1 | Block takes the DMA input byte |
| dma_rd_data | input | 8 | DMA input byte |
| dma_wr_valid | output | 1 | Byte offered to the DMA output |
| dma_wr_ready | input | 1 | DMA output can take a byte |
| dma_wr_data | output | 8 | Byte offered to the DMA output |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at burst end |
| done_bytes | output | 21 | Payload bytes moved by the last finished burst |
| underrun | output | 1 | Count was shorter than the address-derived length |
| shortfall | output | 21 | Bytes missing when underrun is set |

## Verification
The bench goes after the edge where the payload gives way to the tail. A design that compared the index off by one would pad or drop one byte too many or too few, and the per-cycle comparison of `bus_rdata` and `dma_wr_valid` catches that. It also runs a byte-mode count of 0, a block-mode count of 0, and addresses at and above the window end. A design that took 0 literally, or that let the address subtraction wrap, would run a burst of the wrong length or move stray bytes into the DMA stream. Stalls on the DMA side are mixed with gaps in the bus strobe, so a design that acknowledged a bus byte without a DMA handshake would drop or duplicate data. The bench also raises a start in the middle of a burst, which shows whether the design wrongly takes in a new command.

// File: rtl/blw_pkg.sv
package blw_pkg;
    localparam int ADDR_W    = 17;
    localparam int CNT_W     = 9;
    localparam int BSZ_W     = 12;
    localparam int LEN_W     = CNT_W + BSZ_W;
    localparam int BYTE_W    = 8;
    localparam int ZERO_CNT  = 512;
    localparam logic [ADDR_W-1:0] WIN_END = 17'h1F800;

    typedef logic [LEN_W-1:0] len_t;

    typedef struct packed {
        logic rd;
        len_t xfer;
        len_t pay;
    } plan_t;

    typedef enum logic {ST_IDLE, ST_RUN} seq_st_e;

    function automatic len_t req_len(input logic [ADDR_W-1:0] a);
        return (a < WIN_END) ? len_t'(WIN_END - a) : '0;
    endfunction

    function automatic len_t min_len(input len_t a, input len_t b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/blw_len_calc.sv
module blw_len_calc
    import blw_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    input  logic              blk_mode,
    input  logic              rd,
    input  logic [BSZ_W-1:0]  blk_size,
    output plan_t             plan,
    output logic              under,
    output len_t              short_by
);
    len_t req;
    len_t xfer;

    always_comb begin
        req = req_len(addr);
        if (blk_mode)
            xfer = len_t'(count) * len_t'(blk_size);
        else if (count == '0)
            xfer = len_t'(ZERO_CNT);
        else
            xfer = len_t'(count);
        plan.rd   = rd;
        plan.xfer = xfer;
        plan.pay  = min_len(req, xfer);
        under     = (xfer < req);
        short_by  = under ? (req - xfer) : '0;
    end
endmodule

// File: rtl/blw_seq.sv
module blw_seq
    import blw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  plan_t plan_in,
    input  logic  under_in,
    input  len_t  short_in,
    input  logic  bus_fire,
    output logic  busy,
    output logic  in_pay,
    output logic  rd,
    output logic  done,
    output len_t  done_bytes,
    output logic  underrun,
    output len_t  shortfall
);
    seq_st_e st;
    plan_t   plan_q;
    len_t    idx;
    logic    last;

    assign busy   = (st == ST_RUN);
    assign in_pay = (idx < plan_q.pay);
    assign rd     = plan_q.rd;
    assign last   = (idx == plan_q.xfer - len_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            plan_q     <= '0;
            idx        <= '0;
            done       <= 1'b0;
            done_bytes <= '0;
            underrun   <= 1'b0;
            shortfall  <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        plan_q    <= plan_in;
                        idx       <= '0;
                        underrun  <= under_in;
                        shortfall <= short_in;
                        if (plan_in.xfer == '0) begin
                            done       <= 1'b1;
                            done_bytes <= '0;
                        end else begin
                            st <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (bus_fire) begin
                        idx <= idx + len_t'(1);
                        if (last) begin
                            st         <= ST_IDLE;
                            done       <= 1'b1;
                            done_bytes <= plan_q.pay;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/blw_steer.sv
module blw_steer
    import blw_pkg::*;
(
    input  logic              busy,
    input  logic              in_pay,
    input  logic              rd,
    input  logic              bus_stb,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              dma_rd_valid,
    input  logic [BYTE_W-1:0] dma_rd_data,
    input  logic              dma_wr_ready,
    output logic              bus_ack,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              dma_rd_ready,
    output logic              dma_wr_valid,
    output logic [BYTE_W-1:0] dma_wr_data,
    output logic              bus_fire
);
    always_comb begin
        bus_ack      = 1'b0;
        bus_rdata    = '0;
        dma_rd_ready = 1'b0;
        dma_wr_valid = 1'b0;
        if (busy) begin
            if (in_pay) begin
                if (rd) begin
                    bus_ack      = dma_rd_valid;
                    dma_rd_ready = bus_stb;
                    bus_rdata    = dma_rd_data;
                end else begin
                    bus_ack      = dma_wr_ready;
                    dma_wr_valid = bus_stb;
                end
            end else begin
                bus_ack = 1'b1;
            end
        end
    end

    assign dma_wr_data = bus_wdata;
    assign bus_fire    = bus_stb && bus_ack;
endmodule

// File: rtl/blen_window.sv
module blen_window
    import blw_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W,
    parameter int BW = BSZ_W,
    parameter int DW = BYTE_W,
    localparam int LW = AW > 0 ? LEN_W : LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] cmd_addr,
    input  logic [CW-1:0] cmd_count,
    input  logic          cmd_block,
    input  logic          cmd_read,
    input  logic [BW-1:0] blk_size,
    input  logic          bus_stb,
    output logic          bus_ack,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          dma_rd_valid,
    output logic          dma_rd_ready,
    input  logic [DW-1:0] dma_rd_data,
    output logic          dma_wr_valid,
    input  logic          dma_wr_ready,
    output logic [DW-1:0] dma_wr_data,
    output logic          busy,
    output logic          done,
    output logic [LW-1:0] done_bytes,
    output logic          underrun,
    output logic [LW-1:0] shortfall
);
    plan_t plan;
    logic  under_c;
    len_t  short_c;
    logic  in_pay;
    logic  rd_cur;
    logic  bus_fire;

    blw_len_calc u_calc (
        .addr     (cmd_addr),
        .count    (cmd_count),
        .blk_mode (cmd_block),
        .rd       (cmd_read),
        .blk_size (blk_size),
        .plan     (plan),
        .under    (under_c),
        .short_by (short_c)
    );

    blw_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .plan_in    (plan),
        .under_in   (under_c),
        .short_in   (short_c),
        .bus_fire   (bus_fire),
        .busy       (busy),
        .in_pay     (in_pay),
        .rd         (rd_cur),
        .done       (done),
        .done_bytes (done_bytes),
        .underrun   (underrun),
        .shortfall  (shortfall)
    );

    blw_steer u_steer (
        .busy         (busy),
        .in_pay       (in_pay),
        .rd           (rd_cur),
        .bus_stb      (bus_stb),
        .bus_wdata    (bus_wdata),
        .dma_rd_valid (dma_rd_valid),
        .dma_rd_data  (dma_rd_data),
        .dma_wr_ready (dma_wr_ready),
        .bus_ack      (bus_ack),
        .bus_rdata    (bus_rdata),
        .dma_rd_ready (dma_rd_ready),
        .dma_wr_valid (dma_wr_valid),
        .dma_wr_data  (dma_wr_data),
        .bus_fire     (bus_fire)
    );
endmodule

// File: rtl/blen_window_chk.sv
module blen_window_chk #(
    parameter int DW = 8,
    parameter int LW = 21
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          in_pay,
    input logic          rd_cur,
    input logic          bus_ack,
    input logic [DW-1:0] bus_rdata,
    input logic          dma_rd_valid,
    input logic          dma_rd_ready,
    input logic          dma_wr_valid,
    input logic          dma_wr_ready,
    input logic          underrun,
    input logic [LW-1:0] shortfall
);
    AST_WR_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (dma_wr_valid && !dma_wr_ready) |-> !bus_ack); // R7
    AST_RD_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (dma_rd_ready && !dma_rd_valid) |-> !bus_ack); // R7
    AST_PAD_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_cur && !in_pay) |-> (bus_rdata == '0 && !dma_rd_ready)); // R4
    AST_TAIL_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (busy && !rd_cur && !in_pay) |-> !dma_wr_valid); // R5
    AST_UNDER_MATCHES_SHORT: assert property (@(posedge clk) disable iff (rst)
        underrun == (shortfall != '0)); // R6
    AST_DONE_LEAVES_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bus_ack && !dma_wr_valid && !dma_rd_ready)); // R10
endmodule

bind blen_window blen_window_chk #(.DW(DW), .LW(LW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .done         (done),
    .in_pay       (in_pay),
    .rd_cur       (rd_cur),
    .bus_ack      (bus_ack),
    .bus_rdata    (bus_rdata),
    .dma_rd_valid (dma_rd_valid),
    .dma_rd_ready (dma_rd_ready),
    .dma_wr_valid (dma_wr_valid),
    .dma_wr_ready (dma_wr_ready),
    .underrun     (underrun),
    .shortfall    (shortfall)
);

// File: tb/blen_window_tb.sv
module blen_window_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st = 1'b0;
    logic [16:0] s_addr = '0;
    logic [8:0]  s_cnt = '0;
    logic        s_blk = 1'b0;
    logic        s_rd = 1'b0;
    logic [11:0] s_bsz = '0;
    logic        bus_stb = 1'b0;
    logic        bus_ack;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        dma_rd_valid = 1'b0;
    logic        dma_rd_ready;
    logic [7:0]  dma_rd_data;
    logic        dma_wr_valid;
    logic        dma_wr_ready = 1'b0;
    logic [7:0]  dma_wr_data;
    logic        busy, done, underrun;
    logic [20:0] done_bytes, shortfall;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int smode = 0;
    int rd_seq = 0;
    int pulled = 0;
    int fwd = 0;
    int bus_moves = 0;

    bit m_busy = 0, m_rd = 0, m_done = 0;
    int m_idx = 0, m_pay = 0, m_xl = 0, m_dbytes = 0;

    always #10 clk = ~clk;

    assign dma_rd_data = rd_seq[7:0];

    blen_window u_dut (
        .clk(clk), .rst(rst), .start(st), .cmd_addr(s_addr), .cmd_count(s_cnt),
        .cmd_block(s_blk), .cmd_read(s_rd), .blk_size(s_bsz),
        .bus_stb(bus_stb), .bus_ack(bus_ack), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_rd_valid(dma_rd_valid), .dma_rd_ready(dma_rd_ready), .dma_rd_data(dma_rd_data),
        .dma_wr_valid(dma_wr_valid), .dma_wr_ready(dma_wr_ready), .dma_wr_data(dma_wr_data),
        .busy(busy), .done(done), .done_bytes(done_bytes),
        .underrun(underrun), .shortfall(shortfall)
    );

    function automatic int req_of(input int a);
        return (a < 'h1F800) ? ('h1F800 - a) : 0;
    endfunction

    function automatic int xl_of(input int c, input bit b, input int bs);
        if (b) return c * bs;
        return (c == 0) ? 512 : c;
    endfunction

    function automatic bit exp_ack();
        if (!m_busy) return 1'b0;
        if (m_idx < m_pay) return m_rd ? dma_rd_valid : dma_wr_ready;
        return 1'b1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_idx = 0; m_pay = 0; m_xl = 0; m_dbytes = 0; m_rd = 0;
        end else begin
            if (dma_rd_valid && dma_rd_ready) begin rd_seq++; pulled++; end
            if (dma_wr_valid && dma_wr_ready) fwd++;
            if (bus_stb && bus_ack) bus_moves++;
            m_done = 0;
            if (!m_busy) begin
                if (st) begin
                    m_xl  = xl_of(int'(s_cnt), s_blk, int'(s_bsz));
                    m_pay = (req_of(int'(s_addr)) < m_xl) ? req_of(int'(s_addr)) : m_xl;
                    m_rd  = s_rd;
                    m_idx = 0;
                    if (m_xl == 0) begin m_done = 1; m_dbytes = 0; end
                    else m_busy = 1;
                end
            end else if (bus_stb && exp_ack()) begin
                if (m_idx == m_xl - 1) begin m_busy = 0; m_done = 1; m_dbytes = m_pay; end
                m_idx++;
            end
        end
    end

    task automatic compare();
        int er;
        er = (m_busy && m_rd && m_idx < m_pay) ? int'(dma_rd_data) : 0;
        chk(busy == m_busy, "R9", "busy", busy, m_busy);
        chk(bus_ack == exp_ack(), "R7", "bus_ack", bus_ack, exp_ack());
        chk(int'(bus_rdata) == er, "R4", "bus_rdata", bus_rdata, er);
        chk(dma_rd_ready == (m_busy && m_rd && m_idx < m_pay && bus_stb), "R4", "dma_rd_ready",
            dma_rd_ready, (m_busy && m_rd && m_idx < m_pay && bus_stb));
        chk(dma_wr_valid == (m_busy && !m_rd && m_idx < m_pay && bus_stb), "R5", "dma_wr_valid",
            dma_wr_valid, (m_busy && !m_rd && m_idx < m_pay && bus_stb));
        if (dma_wr_valid) chk(dma_wr_data == bus_wdata, "R5", "dma_wr_data", dma_wr_data, bus_wdata);
        chk(done == m_done, "R8", "done", done, m_done);
        if (m_done) chk(int'(done_bytes) == m_dbytes, "R8", "done_bytes", done_bytes, m_dbytes);
    endtask

    task automatic tick(input bit do_start);
        @(negedge clk);
        compare();
        cyc++;
        bus_stb      = (smode >= 2) ? (cyc % 4 != 0) : 1'b1;
        dma_rd_valid = (smode == 1 || smode == 3) ? (cyc % 3 != 0) : 1'b1;
        dma_wr_ready = (smode == 1 || smode == 3) ? (cyc % 3 != 1) : 1'b1;
        bus_wdata    = cyc[7:0] ^ 8'h5A;
        st           = do_start;
    endtask

    task automatic burst(input int a, input int c, input bit b, input int bs, input bit r,
                         input int mode, input bit poke, input string tag);
        int req, xl, pay, n;
        bit seen;
        req = req_of(a); xl = xl_of(c, b, bs); pay = (req < xl) ? req : xl;
        smode = mode;
        s_addr = a[16:0]; s_cnt = c[8:0]; s_blk = b; s_bsz = bs[11:0]; s_rd = r;
        @(negedge clk);
        pulled = 0; fwd = 0; bus_moves = 0;
        tick(1);
        seen = 0; n = 0;
        while (!seen && n < 3000) begin
            if (poke && n == 3) begin
                s_addr = 17'h1F7FF; s_cnt = 9'd1; s_rd = ~r;
                tick(1);
            end else tick(0);
            if (m_done) seen = 1;
            n++;
        end
        chk(seen, tag, "burst finished", seen, 1);
        tick(0);
        chk(bus_moves == xl, tag, "bus byte count", bus_moves, xl);
        if (r) chk(pulled == pay, "R4", "bytes pulled from DMA", pulled, pay);
        else   chk(fwd == pay, "R5", "bytes forwarded to DMA", fwd, pay);
        chk(underrun == (xl < req), "R6", "underrun", underrun, (xl < req));
        chk(int'(shortfall) == ((xl < req) ? req - xl : 0), "R6", "shortfall",
            shortfall, (xl < req) ? req - xl : 0);
        chk(int'(done_bytes) == pay, tag, "done_bytes after burst", done_bytes, pay);
        if (poke) chk(busy == 0, "R9", "mid-burst start ignored", busy, 0);
        tick(0);
    endtask

    initial begin
        #4_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(busy == 0, "R10", "busy after reset", busy, 0);
        chk(done == 0, "R10", "done after reset", done, 0);
        chk(bus_ack == 0 && dma_wr_valid == 0 && dma_rd_ready == 0, "R10", "quiet after reset",
            {bus_ack, dma_wr_valid, dma_rd_ready}, 0);
        // R4 read with pad, stalls on DMA
        burst('h1F800 - 16, 24, 0, 0, 1, 1, 0, "R4");
        // R5 write with tail drop, bus gaps
        burst('h1F800 - 16, 20, 0, 0, 0, 2, 0, "R5");
        // R6 read underrun
        burst('h1F800 - 40, 10, 0, 0, 1, 3, 0, "R6");
        // R2 byte count 0 means 512, write underrun
        burst('h1F800 - 600, 0, 0, 0, 0, 1, 0, "R2");
        // R3 block mode 3 x 8
        burst('h1F800 - 20, 3, 1, 8, 1, 3, 0, "R3");
        // R3 zero-length block burst
        burst('h1F800 - 5, 0, 1, 8, 1, 0, 0, "R3");
        // R1 address at the window end and above it
        burst('h1F800, 6, 0, 0, 0, 0, 0, "R1");
        burst('h1FFFF, 5, 0, 0, 1, 1, 0, "R1");
        // R1 exact fit
        burst('h1F800 - 7, 7, 0, 0, 1, 0, 0, "R1");
        // R9 start while busy
        burst('h1F800 - 12, 12, 0, 0, 0, 3, 1, "R9");
        burst('h1F800 - 30, 2, 1, 16, 0, 1, 1, "R9");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule